// File: doc/BRIEF.md
# Interrupt Steering Crossbar

The block routes 128 level-sensitive interrupt request lines onto 24 interrupt outputs. The outputs go straight into a downstream interrupt controller. Each request line has its own routing register. That register holds an enable bit and the index of the output that the line should drive. Any number of lines may share one output, and each output is the OR of all enabled lines steered to it.

No request is latched. Each output follows the present level of its sources, and the sources must hold their lines until they are serviced. A request line is asynchronous, so it passes through a two-stage synchroniser. The synchronised level feeds the routing logic and also four read-only status words. The output plane is registered, so outputs cannot glitch while a route is changed.

Software reaches the block through a simple synchronous port. A write is a one-cycle strobe. Read data appears on the cycle after the read strobe.

Top module: `irq_steer_fabric`

## Requirements
- R1: After reset every route is disabled, `irq_o` is all zero and `rdata_o` is zero.
- R2: A routing register is the word at address 0..127 belonging to the request line of the same number. Bit 31 is the enable and bits [4:0] are the output index. On a read, every other bit reads 0.
- R3: Each output is the OR of all synchronised request lines whose enabled route selects that output, so several lines may drive one output.
- R4: A line whose route is disabled, or whose index is 24 or above, drives no output.
- R5: A change on a request line that is set up before clock edge k shows on `irq_o` after edge k+2. It must not show after edge k+1.
- R6: A route write strobed at edge k leaves `irq_o` unchanged after edge k. The new route is reflected after edge k+1.
- R7: A read of address 128+w returns the synchronised levels of request lines 32w..32w+31, with line 32w+b in bit b. The data is on `rdata_o` after the edge that samples the read strobe.
- R8: Writes to addresses 128 and above change no route and no status. Reads of addresses above 131 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 128 | Asynchronous level request lines |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the strobe |
| irq_o | output | 24 | Steered interrupt outputs |

## Verification
A change on a request line is due on the outputs three edges after it is driven. The bench drives lines on a falling edge and samples on the falling edge that follows the third rising edge. For R5 it also samples after one and after two rising edges, to confirm the output has not moved early. A route write is checked once after the write edge and again after the next edge, where the new value must appear. Read data and status are captured on the falling edge after the strobe edge. The inputs are always held for at least three edges before a read, so the status words have settled.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int unsigned N_IN_DEF  = 128;
  localparam int unsigned N_OUT_DEF = 24;
  localparam int unsigned DW        = 32;
  localparam int unsigned IDX_W     = 5;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
  } route_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_steer_pkg::*;
#(
  parameter int unsigned N_IN = N_IN_DEF,
  parameter int unsigned AW   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [N_IN-1:0]      lvl_i,
  output route_t [N_IN-1:0]    route_o,
  output logic [DW-1:0]        rdata_o
);
  localparam int unsigned N_WORD = N_IN / DW;
  localparam int unsigned RIW    = $clog2(N_IN);
  localparam logic [AW-1:0] ST_BASE = AW'(N_IN);
  localparam logic [AW-1:0] ST_END  = AW'(N_IN + N_WORD);

  route_t [N_IN-1:0] route_q;
  logic   [DW-1:0]   rdata_q, rd_d;
  logic              is_route;

  assign is_route = addr_i < ST_BASE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
    end else if (req_i && we_i && is_route) begin
      route_q[addr_i[RIW-1:0]] <= '{en: wdata_i[DW-1], idx: wdata_i[IDX_W-1:0]};
    end
  end

  always_comb begin
    rd_d = '0;
    if (is_route) begin
      rd_d[DW-1]      = route_q[addr_i[RIW-1:0]].en;
      rd_d[IDX_W-1:0] = route_q[addr_i[RIW-1:0]].idx;
    end else if (addr_i < ST_END) begin
      for (int w = 0; w < int'(N_WORD); w++) begin
        if (addr_i == ST_BASE + AW'(w)) rd_d = lvl_i[w*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (req_i && !we_i)    rdata_q <= rd_d;
    else                        rdata_q <= '0;
  end

  assign route_o = route_q;
  assign rdata_o = rdata_q;

  AST_WR_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && is_route) |=>
      route_q[$past(addr_i[RIW-1:0])].en == $past(wdata_i[DW-1])); // R2
  AST_STATUS_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !is_route) |=> $stable(route_q)); // R8
endmodule

// File: rtl/irq_or_plane.sv
module irq_or_plane
  import irq_steer_pkg::*;
#(
  parameter int unsigned N_IN  = N_IN_DEF,
  parameter int unsigned N_OUT = N_OUT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   lvl_i,
  input  route_t [N_IN-1:0] route_i,
  output logic [N_OUT-1:0]  irq_o
);
  logic [N_OUT-1:0] hit_d, irq_q;

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    always_comb begin
      hit_d[j] = 1'b0;
      for (int i = 0; i < int'(N_IN); i++) begin
        hit_d[j] |= lvl_i[i] & route_i[i].en & (route_i[i].idx == IDX_W'(j));
      end
    end
  end

  // registered plane: no combinational glitch reaches the controller
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= hit_d;
  end

  assign irq_o = irq_q;

  AST_OUT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(irq_o) <= $past($countones(lvl_i))); // R3
  AST_OUT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_d) |-> (|lvl_i)); // R4
endmodule

// File: rtl/irq_steer_fabric.sv
module irq_steer_fabric
  import irq_steer_pkg::*;
#(
  parameter int unsigned N_IN  = N_IN_DEF,
  parameter int unsigned N_OUT = N_OUT_DEF,
  parameter int unsigned AW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  irq_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [N_OUT-1:0] irq_o
);
  logic [N_IN-1:0]   lvl;
  route_t [N_IN-1:0] route;

  irq_sync #(.W(N_IN)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_i), .q_o(lvl)
  );

  irq_route_regs #(.N_IN(N_IN), .AW(AW)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .lvl_i(lvl),
    .route_o(route), .rdata_o(rdata_o)
  );

  irq_or_plane #(.N_IN(N_IN), .N_OUT(N_OUT)) i_plane (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .route_i(route),
    .irq_o(irq_o)
  );

  AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (irq_o == '0)); // R1
endmodule

// File: tb/test_irq_steer_fabric.sv
`timescale 1ns/1ps
module test_irq_steer_fabric;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] irq_in = '0;
  logic         req = 1'b0, we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [23:0]  irq_out;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] m_route [128];

  always #2.5 clk = ~clk;

  irq_steer_fabric i_irq_steer_fabric (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq_in), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_out)
  );

  function automatic logic [23:0] exp_out(logic [127:0] v);
    logic [23:0] r = '0;
    for (int i = 0; i < 128; i++)
      if (v[i] && m_route[i][31] && m_route[i][4:0] < 24) r[m_route[i][4:0]] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); req = 0; we = 0;
    if (a < 128) m_route[a] = {d[31], 26'b0, d[4:0]};
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(posedge clk);
    @(negedge clk); d = rdata; req = 0;
  endtask

  task automatic drive(logic [127:0] v);
    @(negedge clk); irq_in = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [127:0] v;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 128; i++) m_route[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    irq_in = '1;
    repeat (4) @(posedge clk); @(negedge clk);
    chk("R1 irq_o after reset", {8'b0, irq_out}, 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);
    rd(8'd5, d); chk("R1 route5 reset", d, 32'h0);

    // R2 format
    drive('0);
    wr(8'd3, 32'h8000_FFE7);
    rd(8'd3, d); chk("R2 readback masks", d, 32'h8000_0007);
    wr(8'd127, 32'h7FFF_0013);
    rd(8'd127, d); chk("R2 disabled readback", d, 32'h0000_0013);

    // R5 latency
    @(negedge clk); irq_in = 128'h8;
    @(posedge clk); @(negedge clk); chk("R5 after 1 edge", {8'b0, irq_out}, 32'h0);
    @(posedge clk); @(negedge clk); chk("R5 after 2 edges", {8'b0, irq_out}, 32'h0);
    @(posedge clk); @(negedge clk); chk("R5 after 3 edges", {8'b0, irq_out}, 32'h80);

    // R6 route change timing
    @(negedge clk); req = 1; we = 1; addr = 8'd3; wdata = 32'h8000_0010;
    @(posedge clk); @(negedge clk); req = 0; we = 0;
    m_route[3] = 32'h8000_0010;
    chk("R6 unchanged after write edge", {8'b0, irq_out}, 32'h80);
    @(posedge clk); @(negedge clk);
    chk("R6 new route next edge", {8'b0, irq_out}, 32'h1_0000);

    // R4 disabled and out-of-range index
    wr(8'd10, 32'h8000_0019);
    wr(8'd11, 32'h8000_001F);
    wr(8'd12, 32'h0000_0002);
    drive(128'h1C00);
    chk("R4 no drive", {8'b0, irq_out}, 32'h0);

    // R3 many-to-one
    wr(8'd20, 32'h8000_0017); wr(8'd90, 32'h8000_0017); wr(8'd127, 32'h8000_0000);
    drive(128'h1 << 90);
    chk("R3 shared out single", {8'b0, irq_out}, {8'b0, exp_out(128'h1 << 90)});
    drive((128'h1 << 20) | (128'h1 << 127));
    chk("R3 two outputs", {8'b0, irq_out}, 32'h80_0001);

    // R7 status words
    v = {$urandom, $urandom, $urandom, $urandom};
    drive(v);
    for (int w = 0; w < 4; w++) begin
      rd(8'(128 + w), d); chk("R7 status word", d, v[w*32 +: 32]);
    end

    // R8 writes to status/out of range ignored
    wr(8'd129, 32'hFFFF_FFFF);
    wr(8'd200, 32'hFFFF_FFFF);
    rd(8'd129, d); chk("R8 status unchanged", d, v[63:32]);
    rd(8'd200, d); chk("R8 high read zero", d, 32'h0);
    drive(v);
    chk("R8 outputs unchanged", {8'b0, irq_out}, {8'b0, exp_out(v)});

    // R3 random
    for (int n = 0; n < 60; n++) begin
      for (int k = 0; k < 6; k++) begin
        logic [6:0] a = 7'($urandom);
        wr({1'b0, a}, {$urandom} & 32'h8000_001F | 32'(($urandom % 2) << 31));
      end
      v = {$urandom, $urandom, $urandom, $urandom};
      if (n % 3 == 0) v = v & {$urandom, $urandom, $urandom, $urandom};
      drive(v);
      chk("R3 random routing", {8'b0, irq_out}, {8'b0, exp_out(v)});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule